// File: doc/BRIEF.md
# Standby and Wake-Up Reset Controller

This block puts a processor core into a clock-stop standby and brings it back. Software arms wake-up through one register, then asks for the clock to stop through a second register. If both steps happen in that order, the block drops the core clock enable at a clock edge. The core's memory and port registers stay frozen at their last values. The block's own logic keeps running on an ungated clock. It watches an 8-bit key port and compares it with a snapshot of the port taken when the clock stopped.

Any difference between the port and the snapshot ends standby. The clock enable returns, and the core is held in reset for a fixed number of cycles (65536 by default). The core is then released and runs again. This wake reset touches only the core's reset line, so memory and port state survive it. A flag tells software that the last reset came from a wake.

A hard request performs a full initialization and takes priority over every other state. Such a request is either the active-low reset pin (asynchronous) or the low-voltage flag (sampled on the clock). It clears the arm bit and the wake flag, and it runs the same timed hold after the request goes away.

Top module: `standby_wake_ctrl`

## Requirements
- R1: The arm register is at bus address ARM_ADDR (default 0), and a write there stores `wr_bit`. A write to STOP_ADDR (default 1) with `wr_bit` = 1 while armed takes effect at the edge that captures it: `cpu_clk_en` is 0 from that edge on.
- R2: A stop write while the arm bit is 0 is ignored: `cpu_clk_en` stays 1 and `cpu_rst` stays 0.
- R3: In standby, `cpu_rst` stays 0 and `cpu_clk_en` stays 0 for as long as the synchronized key port equals the snapshot taken at entry.
- R4: A change in any key bit relative to the snapshot ends standby. Counting the first rising edge that sees the new key value as edge one, the third edge sets `cpu_clk_en` = 1, `cpu_rst` = 1 and `wake_rst_flag` = 1. Until then `cpu_clk_en` stays 0.
- R5: After wake, `cpu_rst` falls at the HOLD_CYC-th rising edge after the edge that entered the hold, so it is high for exactly HOLD_CYC sampled cycles.
- R6: A hard request (`rst_pin_n` low, or `lvd_flag` high at an edge) overrides any state, standby included. It sets `cpu_rst` = 1, `cpu_clk_en` = 1 and `wake_rst_flag` = 0, and clears the arm bit.
- R7: After a hard request goes away, `cpu_rst` stays high for HOLD_CYC sampled cycles, counting the cycle in which the request is removed.
- R8: A wake reset keeps the arm bit: after wake, a stop write with no new arm write enters standby again.
- R9: Key port changes outside standby have no effect on `cpu_rst` or `cpu_clk_en`.
- R10: After a hard reset the arm bit is 0, so a stop write with no arm write first is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated always-on clock |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| lvd_flag | input | 1 | Low-voltage detect, synchronous hard request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_bit | input | 1 | Register write data |
| key_in | input | KEY_W | Key port pins (asynchronous) |
| cpu_clk_en | output | 1 | Registered enable for the core clock gate |
| cpu_rst | output | 1 | Core reset, active high |
| wake_rst_flag | output | 1 | 1 after a wake reset, 0 after a hard reset |

## Verification
A register write is due at the negative edge that follows the capturing edge. A key change first crosses the two-stage synchronizer, so its wake result is due three edges after the change. The bench checks that `cpu_clk_en` is still low one sample before that point and has risen at it. Both hold lengths are measured by counting the sampled cycles in which `cpu_rst` is high and comparing the count with HOLD_CYC. A low-voltage pulse is checked one sample after the edge that sees it.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STBY  = 2'd1,
    ST_WHOLD = 2'd2,
    ST_HRST  = 2'd3
  } swk_state_e;

  // hold states keep the core in reset and count
  function automatic logic in_hold(input swk_state_e s);
    return (s == ST_WHOLD) || (s == ST_HRST);
  endfunction

  // terminal count of a window of lim cycles starting at zero
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

endpackage

// File: rtl/swk_key_watch.sv
module swk_key_watch #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             snap_en,
  input  logic [KEY_W-1:0] key_in,
  output logic             wake_evt
);

  logic [KEY_W-1:0] sync1_q;
  logic [KEY_W-1:0] sync2_q;
  logic [KEY_W-1:0] snap_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      snap_q  <= '0;
    end else begin
      sync1_q <= key_in;
      sync2_q <= sync1_q;
      if (snap_en) snap_q <= sync2_q;
    end
  end

  // any bit differing from the entry snapshot
  assign wake_evt = |(sync2_q ^ snap_q);

endmodule

// File: rtl/swk_hold_timer.sv
module swk_hold_timer #(
  parameter int HOLD_CYC = 65536
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = swk_pkg::at_last(int'(cnt_q), HOLD_CYC);

endmodule

// File: rtl/swk_ctrl_fsm.sv
module swk_ctrl_fsm
  import swk_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       lvd,
  input  logic       arm_wr,
  input  logic       arm_val,
  input  logic       stop_wr,
  input  logic       wake_evt,
  input  logic       hold_done,
  output swk_state_e state_q,
  output logic       arm_q,
  output logic       clk_en_q,
  output logic       rst_q,
  output logic       wflag_q,
  output logic       snap_en,
  output logic       cnt_clr,
  output logic       cnt_inc
);

  swk_state_e state_nxt;

  always_comb begin
    state_nxt = state_q;
    if (lvd) begin
      state_nxt = ST_HRST;
    end else begin
      unique case (state_q)
        ST_RUN:   if (stop_wr && arm_q) state_nxt = ST_STBY;
        ST_STBY:  if (wake_evt)         state_nxt = ST_WHOLD;
        ST_WHOLD: if (hold_done)        state_nxt = ST_RUN;
        ST_HRST:  if (hold_done)        state_nxt = ST_RUN;
        default:                        state_nxt = ST_HRST;
      endcase
    end
  end

  assign snap_en = (state_q == ST_RUN) && (state_nxt == ST_STBY);
  assign cnt_clr = lvd || !in_hold(state_q);
  assign cnt_inc = !cnt_clr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= ST_HRST;
      arm_q    <= 1'b0;
      clk_en_q <= 1'b1;
      rst_q    <= 1'b1;
      wflag_q  <= 1'b0;
    end else begin
      state_q  <= state_nxt;
      clk_en_q <= (state_nxt != ST_STBY);
      rst_q    <= in_hold(state_nxt);
      if (lvd)                                 arm_q <= 1'b0;
      else if (arm_wr && state_q == ST_RUN)    arm_q <= arm_val;
      if (lvd)                                 wflag_q <= 1'b0;
      else if (state_q == ST_STBY && state_nxt == ST_WHOLD) wflag_q <= 1'b1;
    end
  end

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import swk_pkg::*;
#(
  parameter int KEY_W     = 8,
  parameter int HOLD_CYC  = 65536,
  parameter int ADDR_W    = 2,
  parameter int ARM_ADDR  = 0,
  parameter int STOP_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              lvd_flag,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [KEY_W-1:0]  key_in,
  output logic              cpu_clk_en,
  output logic              cpu_rst,
  output logic              wake_rst_flag
);

  logic       arm_wr;
  logic       stop_wr;
  logic       wake_evt;
  logic       hold_done;
  logic       snap_en;
  logic       cnt_clr;
  logic       cnt_inc;
  logic       arm_q;
  logic       in_stby;
  swk_state_e state_q;

  assign arm_wr  = wr_en && (wr_addr == ADDR_W'(ARM_ADDR));
  assign stop_wr = wr_en && (wr_addr == ADDR_W'(STOP_ADDR)) && wr_bit;
  assign in_stby = (state_q == ST_STBY);

  swk_key_watch #(.KEY_W(KEY_W)) key_i (
    .clk      (clk),
    .arst_n   (rst_pin_n),
    .snap_en  (snap_en),
    .key_in   (key_in),
    .wake_evt (wake_evt)
  );

  swk_hold_timer #(.HOLD_CYC(HOLD_CYC)) tmr_i (
    .clk    (clk),
    .arst_n (rst_pin_n),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .done   (hold_done)
  );

  swk_ctrl_fsm fsm_i (
    .clk       (clk),
    .arst_n    (rst_pin_n),
    .lvd       (lvd_flag),
    .arm_wr    (arm_wr),
    .arm_val   (wr_bit),
    .stop_wr   (stop_wr),
    .wake_evt  (wake_evt),
    .hold_done (hold_done),
    .state_q   (state_q),
    .arm_q     (arm_q),
    .clk_en_q  (cpu_clk_en),
    .rst_q     (cpu_rst),
    .wflag_q   (wake_rst_flag),
    .snap_en   (snap_en),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc)
  );

endmodule

// File: rtl/swk_checker.sv
module swk_checker (
  input logic clk,
  input logic rst_pin_n,
  input logic lvd_flag,
  input logic cpu_clk_en,
  input logic cpu_rst,
  input logic wake_rst_flag,
  input logic wake_evt,
  input logic hold_done,
  input logic arm_q,
  input logic in_stby
);

  AST_ENTRY_ARMED: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(cpu_clk_en) |-> $past(arm_q)); // R1

  AST_STBY_NO_RST: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !cpu_clk_en |-> !cpu_rst); // R3

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (in_stby && wake_evt && !lvd_flag) |=> (cpu_clk_en && cpu_rst && wake_rst_flag)); // R4

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(cpu_rst) |-> $past(hold_done)); // R5

  AST_HARD_PRIO: assert property (@(posedge clk) disable iff (!rst_pin_n)
    lvd_flag |=> (cpu_rst && cpu_clk_en && !wake_rst_flag && !arm_q)); // R6

  AST_RST_SOURCE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(cpu_rst) |-> ($past(lvd_flag) || !$past(cpu_clk_en))); // R9

endmodule

bind standby_wake_ctrl swk_checker chk_i (
  .clk           (clk),
  .rst_pin_n     (rst_pin_n),
  .lvd_flag      (lvd_flag),
  .cpu_clk_en    (cpu_clk_en),
  .cpu_rst       (cpu_rst),
  .wake_rst_flag (wake_rst_flag),
  .wake_evt      (wake_evt),
  .hold_done     (hold_done),
  .arm_q         (arm_q),
  .in_stby       (in_stby)
);

// File: tb/standby_wake_ctrl_tb.sv
module standby_wake_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 16;
  localparam int KW         = 8;
  localparam logic [1:0] A_ARM  = 2'd0;
  localparam logic [1:0] A_STOP = 2'd1;

  // {arm, expect standby, expect wake, key at entry, key after}
  localparam int NVEC = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h01},
    {1'b1, 1'b1, 1'b1, 8'h80, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'hA5, 8'hA5},
    {1'b0, 1'b0, 1'b0, 8'h3C, 8'hC3},
    {1'b1, 1'b1, 1'b1, 8'hFF, 8'h7E},
    {1'b1, 1'b1, 1'b1, 8'h5A, 8'hA5}
  };

  logic          clk = 1'b0;
  logic          rst_pin_n = 1'b0;
  logic          lvd_flag = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic          wr_bit = 1'b0;
  logic [KW-1:0] key_in = '0;
  logic          cpu_clk_en;
  logic          cpu_rst;
  logic          wake_rst_flag;

  int n_chk = 0;
  int n_bad = 0;
  int n_hi;

  standby_wake_ctrl #(.KEY_W(KW), .HOLD_CYC(HOLD)) dut_i (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .lvd_flag      (lvd_flag),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_bit        (wr_bit),
    .key_in        (key_in),
    .cpu_clk_en    (cpu_clk_en),
    .cpu_rst       (cpu_rst),
    .wake_rst_flag (wake_rst_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic b);
    wr_en = 1'b1; wr_addr = a; wr_bit = b;
    tick();
    wr_en = 1'b0; wr_bit = 1'b0;
  endtask

  // counts sampled cycles with cpu_rst high, starting with the current one
  task automatic wait_release(output int n);
    n = 0;
    while (cpu_rst && n < 1000) begin
      n++;
      tick();
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R6 reset state under the pin
    repeat (3) tick();
    chk("R6 pin rst cpu_rst", cpu_rst, 1);
    chk("R6 pin rst clk_en", cpu_clk_en, 1);
    chk("R6 pin rst flag", wake_rst_flag, 0);
    rst_pin_n = 1'b1;
    wait_release(n_hi);
    chk("R7 pin hold length", n_hi, HOLD);
    chk("R7 clk_en after hold", cpu_clk_en, 1);

    // R10 arm is cleared by hard reset
    bus_write(A_STOP, 1'b1);
    chk("R10 stop ignored after reset", cpu_clk_en, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic          v_arm, v_stby, v_wake;
      logic [KW-1:0] k0, k1;
      {v_arm, v_stby, v_wake, k0, k1} = VEC[i];
      key_in = k0;
      bus_write(A_ARM, v_arm);
      repeat (3) tick();
      bus_write(A_STOP, 1'b1);
      chk(v_stby ? "R1 standby entry" : "R2 stop ignored", cpu_clk_en, v_stby ? 0 : 1);
      chk("R2 R3 no reset at stop", cpu_rst, 0);
      key_in = k1;
      tick(); tick();
      chk("R4 wake not yet", cpu_clk_en, v_stby ? 0 : 1);
      tick();
      if (v_wake) begin
        chk("R4 wake clk_en", cpu_clk_en, 1);
        chk("R4 wake cpu_rst", cpu_rst, 1);
        chk("R4 wake flag", wake_rst_flag, 1);
        wait_release(n_hi);
        chk("R5 wake hold length", n_hi, HOLD);
      end else if (v_stby) begin
        repeat (5) tick();
        chk("R3 stays in standby", cpu_clk_en, 0);
        chk("R3 no reset in standby", cpu_rst, 0);
        key_in = k1 ^ 8'h10;
        repeat (3) tick();
        chk("R4 late wake", cpu_rst, 1);
        wait_release(n_hi);
        chk("R5 late wake hold", n_hi, HOLD);
      end else begin
        chk("R9 key in run clk_en", cpu_clk_en, 1);
        chk("R9 key in run cpu_rst", cpu_rst, 0);
      end
    end

    // R8 arm kept across wake reset
    bus_write(A_STOP, 1'b1);
    chk("R8 re-entry without arm", cpu_clk_en, 0);
    chk("R3 flag kept in standby", wake_rst_flag, 1);

    // R6 hard request during standby
    lvd_flag = 1'b1;
    tick();
    chk("R6 lvd in standby clk_en", cpu_clk_en, 1);
    chk("R6 lvd in standby cpu_rst", cpu_rst, 1);
    chk("R6 lvd clears flag", wake_rst_flag, 0);
    repeat (4) tick();
    lvd_flag = 1'b0;
    wait_release(n_hi);
    chk("R7 lvd hold length", n_hi, HOLD);
    bus_write(A_STOP, 1'b1);
    chk("R10 stop ignored after lvd", cpu_clk_en, 1);

    // R9 key toggling while running
    key_in = ~key_in;
    repeat (4) tick();
    chk("R9 run key cpu_rst", cpu_rst, 0);
    chk("R9 run key clk_en", cpu_clk_en, 1);

    // R6 hard request in the middle of a wake hold
    bus_write(A_ARM, 1'b1);
    repeat (3) tick();
    bus_write(A_STOP, 1'b1);
    key_in = key_in ^ 8'h02;
    repeat (3) tick();
    chk("R4 wake before lvd", wake_rst_flag, 1);
    repeat (3) tick();
    lvd_flag = 1'b1;
    tick();
    chk("R6 lvd in hold flag", wake_rst_flag, 0);
    lvd_flag = 1'b0;
    wait_release(n_hi);
    chk("R7 hold restarts", n_hi, HOLD);

    report();
  end

endmodule